// File: doc/BRIEF.md
# Half-Step Stepper Coil Sequencer

This block drives the four coil lines of a unipolar stepping motor through an eight-phase half-step cycle. It keeps a 3-bit phase index and moves it one place per step. The direction input decides whether the index goes up or down, and the index wraps at both ends. The coil pattern for the new phase appears on the low nibble of an 8-bit port byte. A one-cycle strobe marks the cycle in which that pattern first appears, so a downstream port writer knows when to send the byte.

A 3-bit speed code sets the time between steps. The dwell is the speed code multiplied by 255, counted in cycles where the tick enable is high. The enable lets the step rate be scaled down from the system clock. A speed code of 0 is treated as a dwell of one tick, so the motor then steps at its fastest rate and never stalls.

The upper nibble of the port byte is always driven high. This keeps those expander pins usable as inputs, for example for the direction and speed switches.

Top module: `stepper_seq`

## Requirements
- R1: While `rst_n` is low, `port_o` is 0xF0 (index 0, all coils off) and `step_o` is 0. Internal reset is released on the second rising clock edge with `rst_n` high. The third such edge is the first one that can step.
- R2: With `dir_i` = 0, each step increments the index, and index 7 wraps to 0. `port_o[3:0]` shows the phase table, indexed 0 to 7: 0x1, 0x3, 0x2, 0x6, 0x4, 0xC, 0x8, 0x9. The first step after reset therefore shows 0x3.
- R3: With `dir_i` = 1, each step decrements the index, and index 0 wraps to 7. The first step after reset therefore shows 0x9.
- R4: With a nonzero speed code S, steps are exactly S×255 tick-enabled cycles apart.
- R5: With speed code 0, a step happens on every tick-enabled cycle.
- R6: `dir_i` and `speed_i` are sampled only on the edge that performs a step. Changes between steps do not move the index. They also do not alter the dwell already loaded.
- R7: The dwell counter moves only on cycles with `tick_en` high. No step happens without `tick_en` high at the stepping edge.
- R8: `step_o` is high for exactly the one cycle in which a new pattern first appears on `port_o[3:0]`. The pattern does not change in any other cycle.
- R9: `port_o[7:4]` is 0xF in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Free-running enable that advances the dwell counter |
| dir_i | input | 1 | Rotation direction: 0 steps up the table, 1 steps down |
| speed_i | input | 3 | Speed code; dwell is code × 255 ticks, code 0 gives one tick |
| port_o | output | 8 | Port byte: coil pattern in bits 3:0, bits 7:4 held at 1 |
| step_o | output | 1 | One-cycle strobe when a new pattern is presented |

## Verification
The bound checker tests these properties on every cycle:
- The upper nibble is always high.
- A strobe always follows an enabled tick.
- The pattern holds still whenever there is no strobe.
- Each new pattern is the table neighbour of the previous one, in the direction sampled at the stepping edge.
- A strobe under speed code 0 with the enable held high is followed by another strobe.

The exact dwell length of S×255 ticks cannot be checked per cycle, and neither can the wraps across long runs. The same holds for the one-dwell latency before a changed speed or direction takes effect, and for the two-edge reset release. Only the bench's cycle-accurate reference model and its directed interval measurements can show these.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  localparam int PHASES = 8;
  localparam int IDX_W  = $clog2(PHASES);
  localparam int COIL_W = 4;

  // Half-step phase table: single coils alternate with adjacent coil pairs.
  function automatic logic [COIL_W-1:0] phase_pattern(input logic [IDX_W-1:0] idx);
    logic [COIL_W-1:0] pat;
    case (idx)
      3'd0:    pat = 4'h1;
      3'd1:    pat = 4'h3;
      3'd2:    pat = 4'h2;
      3'd3:    pat = 4'h6;
      3'd4:    pat = 4'h4;
      3'd5:    pat = 4'hC;
      3'd6:    pat = 4'h8;
      default: pat = 4'h9;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/stepper_dwell.sv
module stepper_dwell #(
  parameter int SPEED_W    = 3,
  parameter int DWELL_MULT = 255,
  parameter int CNT_W      = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               fire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;

  // Counter runs from the loaded dwell down to 1; a tick at 1 fires a step.
  always_comb begin
    load_val = CNT_W'(speed_i) * CNT_W'(DWELL_MULT);
    if (speed_i == '0) begin
      load_val = CNT_W'(1);
    end
    fire_o = tick_en && (cnt_q == CNT_W'(1));
    cnt_d  = cnt_q;
    if (fire_o) begin
      cnt_d = load_val;
    end else if (tick_en) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(1);
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/stepper_index.sv
module stepper_index
  import stepper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             dir_i,
  output logic [IDX_W-1:0] idx_next_o
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  // Natural modulo-8 wrap of the index width gives wraparound both ways.
  always_comb begin
    idx_next_o = dir_i ? (idx_q - IDX_W'(1)) : (idx_q + IDX_W'(1));
    idx_d      = adv_i ? idx_next_o : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/stepper_coil_drive.sv
module stepper_coil_drive
  import stepper_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PORT_W-1:0] port_o,
  output logic              step_o
);

  logic [COIL_W-1:0] coil_q;
  logic [COIL_W-1:0] coil_d;
  logic              step_q;
  logic              step_d;

  always_comb begin
    coil_d = load_i ? phase_pattern(idx_i) : coil_q;
    step_d = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coil_q <= '0;
      step_q <= 1'b0;
    end else begin
      coil_q <= coil_d;
      step_q <= step_d;
    end
  end

  assign port_o[COIL_W-1:0] = coil_q;

  // Non-coil bits stay high so the expander can use them as inputs.
  for (genvar g = COIL_W; g < PORT_W; g++) begin : g_keep_high
    assign port_o[g] = 1'b1;
  end

  assign step_o = step_q;

endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int SPEED_W    = 3,
  parameter int DWELL_MULT = 255,
  parameter int PORT_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               dir_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic [PORT_W-1:0]  port_o,
  output logic               step_o
);

  localparam int MAX_DWELL = ((1 << SPEED_W) - 1) * DWELL_MULT;
  localparam int CNT_W     = $clog2(MAX_DWELL + 1);

  logic             rst_meta_q;
  logic             rst_sync_q;
  logic             fire;
  logic [IDX_W-1:0] idx_next;

  // Reset synchronizer: asserts at once, releases on the second edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  stepper_dwell #(
    .SPEED_W   (SPEED_W),
    .DWELL_MULT(DWELL_MULT),
    .CNT_W     (CNT_W)
  ) u_dwell (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick_en(tick_en),
    .speed_i(speed_i),
    .fire_o (fire)
  );

  stepper_index u_index (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .adv_i     (fire),
    .dir_i     (dir_i),
    .idx_next_o(idx_next)
  );

  stepper_coil_drive #(
    .PORT_W(PORT_W)
  ) u_drive (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load_i(fire),
    .idx_i (idx_next),
    .port_o(port_o),
    .step_o(step_o)
  );

endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk
  import stepper_pkg::*;
#(
  parameter int SPEED_W = 3,
  parameter int PORT_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               dir_i,
  input logic [SPEED_W-1:0] speed_i,
  input logic [PORT_W-1:0]  port_o,
  input logic               step_o
);

  // Expected neighbour of a pattern; an unknown pattern (reset) counts as phase 0.
  function automatic logic [COIL_W-1:0] neighbour(input logic [COIL_W-1:0] prev,
                                                  input logic d);
    logic [IDX_W-1:0] pos;
    pos = '0;
    for (int k = 0; k < PHASES; k++) begin
      if (phase_pattern(IDX_W'(k)) == prev) pos = IDX_W'(k);
    end
    return phase_pattern(d ? pos - IDX_W'(1) : pos + IDX_W'(1));
  endfunction

  p_upper_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    port_o[PORT_W-1:COIL_W] == '1);

  p_step_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> $past(tick_en));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_o |-> $stable(port_o[COIL_W-1:0]));

  p_neighbour_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !$past(dir_i)) |->
      port_o[COIL_W-1:0] == neighbour($past(port_o[COIL_W-1:0]), 1'b0));

  p_neighbour_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && $past(dir_i)) |->
      port_o[COIL_W-1:0] == neighbour($past(port_o[COIL_W-1:0]), 1'b1));

  p_fastest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && $past(speed_i) == '0 && tick_en) |=> step_o);

endmodule

bind stepper_seq stepper_seq_chk #(.SPEED_W(SPEED_W), .PORT_W(PORT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick_en(tick_en),
  .dir_i  (dir_i),
  .speed_i(speed_i),
  .port_o (port_o),
  .step_o (step_o)
);

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       dir_i = 1'b0;
  logic [2:0] speed_i = 3'd0;
  logic [7:0] port_o;
  logic       step_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    run_cmp = 1'b0;
  string cur_req = "R1";

  // Reference model state.
  int m_idx = 0;
  int m_cnt = 1;
  int m_pat = 0;
  int m_stb = 0;
  int m_sync = 0;
  int tab [8] = '{1, 3, 2, 6, 4, 12, 8, 9};

  always #5 clk = ~clk;

  stepper_seq dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .dir_i  (dir_i),
    .speed_i(speed_i),
    .port_o (port_o),
    .step_o (step_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural model, one step of the requirement text per rising edge.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_sync = 0; m_idx = 0; m_cnt = 1; m_pat = 0; m_stb = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      m_stb = 0;
      if (tick_en) begin
        if (m_cnt == 1) begin
          m_idx = dir_i ? (m_idx + 7) % 8 : (m_idx + 1) % 8;
          m_pat = tab[m_idx];
          m_stb = 1;
          m_cnt = (speed_i == 0) ? 1 : int'(speed_i) * 255;
        end else begin
          m_cnt--;
        end
      end
    end
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(port_o[3:0] == 4'(m_pat), cur_req, int'(port_o[3:0]), m_pat);
      chk(step_o == 1'(m_stb), "R8 strobe", int'(step_o), m_stb);
      chk(port_o[7:4] == 4'hF, "R9 upper nibble", int'(port_o[7:4]), 15);
    end
  end

  task automatic run(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      tick_en = (i % per == 0);
      @(negedge clk);
    end
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!step_o && n < 5000);
  endtask

  initial begin
    int n;
    int cnt;
    repeat (3) @(negedge clk);
    run_cmp = 1'b1;
    // R1: reset state
    chk(port_o == 8'hF0, "R1 reset byte", int'(port_o), 'hF0);
    chk(step_o == 1'b0, "R1 reset strobe", int'(step_o), 0);
    rst_n = 1'b1; tick_en = 1'b1; dir_i = 1'b0; speed_i = 3'd0;
    repeat (2) @(negedge clk);
    chk(port_o == 8'hF0, "R1 sync release", int'(port_o), 'hF0);
    @(negedge clk);
    chk(port_o == 8'hF3 && step_o, "R2 first step up", int'(port_o), 'hF3);
    // R2 / R5: forward wrap at fastest rate
    cur_req = "R2";
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (step_o) cnt++;
    end
    chk(cnt == 16, "R5 step every tick", cnt, 16);
    run(4, 1);
    // R3: reverse wrap
    cur_req = "R3";
    dir_i = 1'b1;
    run(20, 1);
    // R4: dwell length for speed 1 and speed 7
    cur_req = "R4";
    speed_i = 3'd1;
    wait_strobe(n);
    wait_strobe(n);
    chk(n == 255, "R4 dwell speed 1", n, 255);
    speed_i = 3'd7;
    wait_strobe(n);
    wait_strobe(n);
    chk(n == 1785, "R4 dwell speed 7", n, 1785);
    // R7: sparse tick enable
    cur_req = "R7";
    speed_i = 3'd1;
    run(1600, 3);
    tick_en = 1'b0;
    run(1, 1000);
    tick_en = 1'b0;
    repeat (300) @(negedge clk);
    chk(step_o == 1'b0, "R7 no step without tick", int'(step_o), 0);
    // R6: changes mid-dwell only apply at the next step
    cur_req = "R6";
    tick_en = 1'b1; speed_i = 3'd2; dir_i = 1'b0;
    wait_strobe(n);
    wait_strobe(n);
    speed_i = 3'd0; dir_i = 1'b1;
    wait_strobe(n);
    chk(n == 510, "R6 loaded dwell kept", n, 510);
    run(6, 1);
    // R1 mid-run reset, then first step down
    cur_req = "R1";
    @(negedge clk);
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk(port_o == 8'hF0, "R1 async reset byte", int'(port_o), 'hF0);
    chk(step_o == 1'b0, "R1 async reset strobe", int'(step_o), 0);
    dir_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(port_o == 8'hF9, "R3 first step down", int'(port_o), 'hF9);
    cur_req = "R3";
    run(10, 1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule